// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns an active-low external interrupt pin into a pending interrupt and a masked request line to a processor. The pin passes through a two-flop synchronizer. A falling edge on the synchronized level sets a pending latch. In the optional level mode, the latch is also held set for as long as the pin stays low. Software reaches one 8-bit status and control register through a small single-register bus. From that register it reads the pending flag, acknowledges the interrupt, masks the request and selects the trigger mode.

While the system is halted for debugging (`dbg_halt` high), acknowledge writes normally leave the pending latch alone, so a debugger poking the register cannot lose an interrupt. When `halt_clr_en` is high, acknowledges are honoured during the halt. A latch cleared that way stays cleared after the halt ends.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After synchronous reset every register bit reads 0 and `irq_req` is 0.
- R2: Register layout: bit 3 = pending flag (read-only), bit 2 = acknowledge (write-only, reads 0), bit 1 = mask (1 blocks the request), bit 0 = trigger mode (0 edge only, 1 edge and level). Bits 7..4 read 0. Mask and mode read back as last written.
- R3: A falling edge of `irq_pin_n` sets the pending flag. The flag becomes visible after the third rising clock edge following the pin change. The flag never sets without a falling edge or a level-mode low pin.
- R4: In edge mode, a write with bit 2 = 1 clears the pending flag, and it stays clear while the pin remains low. A write with bit 2 = 0 leaves the flag unchanged.
- R5: In level mode, while the synchronized pin is low, the pending flag stays set and acknowledges have no effect. Once the pin is back high, an acknowledge clears it.
- R6: `irq_req` is 1 exactly when the pending flag is 1 and the mask is 0. The mask does not stop the flag from being set.
- R7: When a falling edge and an acknowledge land in the same clock cycle, the pending flag ends up set.
- R8: While `dbg_halt` is 1 and `halt_clr_en` is 0, acknowledge writes leave the pending flag set.
- R9: While `dbg_halt` is 1 and `halt_clr_en` is 1, an acknowledge clears the pending flag, and it stays clear after `dbg_halt` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register contents, always presented |
| dbg_halt | input | 1 | Debug halt state |
| halt_clr_en | input | 1 | Allows acknowledges during a halt |
| irq_req | output | 1 | Masked interrupt request to the processor |

## Verification
The checker enforces several rules on every cycle:
- The reserved and acknowledge bits read zero.
- The request never rises while the mask is set.
- The pending flag never rises without a detected edge or a low pin in level mode.
- A detected edge always leaves the flag set.
- The flag cannot drop during a protected halt or while a level-mode pin is low.

Only the directed scenarios can show the rest: the three-edge latency from pin to flag, that acknowledges actually clear the flag in edge mode, the clear-then-stay-clear sequence around a halt, and the exact cycle in which an edge and an acknowledge coincide.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int REG_W    = 8;
    localparam int POS_PEND = 3;
    localparam int POS_ACK  = 2;
    localparam int POS_MASK = 1;
    localparam int POS_MODE = 0;

    typedef enum logic {
        TRIG_EDGE       = 1'b0,
        TRIG_EDGE_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic       mask;
        trig_mode_e mode;
    } irq_ctrl_t;

    localparam irq_ctrl_t CTRL_RESET = '{mask: 1'b0, mode: TRIG_EDGE};

    function automatic logic [REG_W-1:0] pack_status(input logic pend, input irq_ctrl_t c);
        logic [REG_W-1:0] r;
        r           = '0;
        r[POS_PEND] = pend;
        r[POS_MASK] = c.mask;
        r[POS_MODE] = c.mode;
        return r;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], pin_async};
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_s,
    input  trig_mode_e mode,
    output logic       fall_evt,
    output logic       set_req
);
    logic pin_prev_q;

    always_ff @(posedge clk) begin
        if (rst) pin_prev_q <= 1'b1;
        else     pin_prev_q <= pin_s;
    end

    always_comb begin
        fall_evt = pin_prev_q & ~pin_s;
        set_req  = fall_evt | ((mode == TRIG_EDGE_LEVEL) & ~pin_s);
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import ext_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_ack,
    input  logic      wr_mask,
    input  logic      wr_mode,
    input  logic      dbg_halt,
    input  logic      halt_clr_en,
    output irq_ctrl_t ctrl,
    output logic      ack_pulse
);
    irq_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_en) begin
            ctrl_q.mask <= wr_mask;
            ctrl_q.mode <= trig_mode_e'(wr_mode);
        end
    end

    assign ctrl      = ctrl_q;
    assign ack_pulse = wr_en & wr_ack & (~dbg_halt | halt_clr_en);
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic pend
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)          pend_q <= 1'b0;
        else if (set_req) pend_q <= 1'b1;
        else if (clr_req) pend_q <= 1'b0;
    end

    assign pend = pend_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_pin_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             dbg_halt,
    input  logic             halt_clr_en,
    output logic             irq_req
);
    logic      pin_s;
    logic      fall_evt;
    logic      set_req;
    logic      ack_pulse;
    logic      pend;
    logic      wr_en;
    irq_ctrl_t ctrl;
    logic      wdata_unused;

    assign wr_en        = bus_sel & bus_wr;
    assign wdata_unused = ^{bus_wdata[REG_W-1:POS_PEND]};

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_async(irq_pin_n), .pin_sync(pin_s)
    );

    irq_trig_detect u_trig (
        .clk(clk), .rst(rst), .pin_s(pin_s), .mode(ctrl.mode),
        .fall_evt(fall_evt), .set_req(set_req)
    );

    irq_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .wr_ack(bus_wdata[POS_ACK]), .wr_mask(bus_wdata[POS_MASK]),
        .wr_mode(bus_wdata[POS_MODE]),
        .dbg_halt(dbg_halt), .halt_clr_en(halt_clr_en),
        .ctrl(ctrl), .ack_pulse(ack_pulse)
    );

    irq_pend_latch u_pend (
        .clk(clk), .rst(rst), .set_req(set_req), .clr_req(ack_pulse), .pend(pend)
    );

    assign bus_rdata = pack_status(pend, ctrl);
    assign irq_req   = pend & ~ctrl.mask;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rdata,
    input logic       irq_req,
    input logic       pin_s,
    input logic       fall_evt,
    input logic       dbg_halt,
    input logic       halt_clr_en
);
    logic pend, mask, lvl;
    assign pend = rdata[3];
    assign mask = rdata[1];
    assign lvl  = rdata[0];

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rdata[7:4] == 4'h0) && !rdata[2]);                               // R2
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        mask |-> !irq_req);                                               // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!pend && !fall_evt && !(lvl && !pin_s)) |=> !pend);              // R3
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
        fall_evt |=> pend);                                               // R7
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lvl && !pin_s) |=> pend);                                        // R5
    AST_HALT_GUARD: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt && !halt_clr_en && pend) |=> pend);                     // R8
endmodule

bind ext_irq_ctrl ext_irq_chk u_chk (
    .clk(clk), .rst(rst), .rdata(bus_rdata), .irq_req(irq_req),
    .pin_s(pin_s), .fall_evt(fall_evt),
    .dbg_halt(dbg_halt), .halt_clr_en(halt_clr_en)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_pin_n = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       dbg_halt = 1'b0;
    logic       halt_clr_en = 1'b0;
    logic       irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ext_irq_ctrl u0 (
        .clk(clk), .rst(rst), .irq_pin_n(irq_pin_n), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_halt(dbg_halt), .halt_clr_en(halt_clr_en), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic pin_set(input logic v);
        @(negedge clk);
        irq_pin_n = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 rdata after reset", bus_rdata, 8'h00);
        check("R1 irq_req after reset", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_layout;
        bus_write(8'hFF);
        check("R2 mask/mode readback, ack and upper bits zero", bus_rdata, 8'h03);
        bus_write(8'h02);
        check("R2 mask only", bus_rdata, 8'h02);
        bus_write(8'h00);
        check("R2 cleared", bus_rdata, 8'h00);
    endtask

    task automatic t_edge;
        @(negedge clk);
        irq_pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R3 not yet set after two edges", {7'b0, bus_rdata[3]}, 8'h00);
        @(negedge clk);
        check("R3 set after third edge", bus_rdata, 8'h08);
        check("R6 unmasked request", {7'b0, irq_req}, 8'h01);
        bus_write(8'h00);
        check("R4 write without ack keeps flag", bus_rdata, 8'h08);
        bus_write(8'h04);
        check("R4 ack clears in edge mode", bus_rdata, 8'h00);
        repeat (4) @(negedge clk);
        check("R4 stays clear with pin low", bus_rdata, 8'h00);
        pin_set(1'b1);
    endtask

    task automatic t_mask;
        bus_write(8'h02);
        pin_set(1'b0);
        check("R6 flag sets while masked", bus_rdata, 8'h0A);
        check("R6 request blocked by mask", {7'b0, irq_req}, 8'h00);
        bus_write(8'h00);
        check("R6 request after unmask", {7'b0, irq_req}, 8'h01);
        bus_write(8'h04);
        pin_set(1'b1);
        check("R6 cleared", bus_rdata, 8'h00);
    endtask

    task automatic t_level;
        bus_write(8'h01);
        pin_set(1'b0);
        check("R5 level set", bus_rdata, 8'h09);
        bus_write(8'h05);
        check("R5 ack ignored while pin low", bus_rdata, 8'h09);
        pin_set(1'b1);
        check("R5 still pending after pin high", bus_rdata, 8'h09);
        bus_write(8'h05);
        check("R5 ack clears after pin high", bus_rdata, 8'h01);
        bus_write(8'h00);
    endtask

    task automatic t_collide;
        @(negedge clk);
        irq_pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h04;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
        check("R7 edge beats ack", bus_rdata, 8'h08);
        pin_set(1'b1);
        bus_write(8'h04);
        check("R7 cleanup", bus_rdata, 8'h00);
    endtask

    task automatic t_halt;
        pin_set(1'b0);
        pin_set(1'b1);
        check("R8 pending before halt", bus_rdata, 8'h08);
        @(negedge clk);
        dbg_halt = 1'b1;
        bus_write(8'h04);
        check("R8 ack blocked during halt", bus_rdata, 8'h08);
        @(negedge clk);
        halt_clr_en = 1'b1;
        bus_write(8'h04);
        check("R9 ack honoured with clear enable", bus_rdata, 8'h00);
        @(negedge clk);
        dbg_halt = 1'b0;
        halt_clr_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 stays clear after halt", bus_rdata, 8'h00);
        check("R9 no request after halt", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_edge();
        t_mask();
        t_level();
        t_collide();
        t_halt();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end
endmodule